// File: doc/BRIEF.md
# Six-bit-pair tape word loader

This block turns a stream of 8-bit tape characters into 12-bit memory writes. Characters arrive one per cycle at most, under a valid/ready handshake. Any character whose top bit is set is thrown away. The survivors are paired, and each one gives up its low 6 bits. The first member of a pair supplies the upper half of the word and the second member supplies the lower half.

Bit 6 of the first member marks the pair as a target address. Without that mark the pair is a data word. The block writes it to the last address loaded. The address does not step on its own, so the tape repeats an address frame whenever it wants a new location.

The loader has no end condition. It accepts characters whenever it is enabled, and it just waits when the stream stops. Deasserting the enable stops acceptance and drops a half-received pair.

Top module: `rim_tape_loader`

## Requirements
- R1: After reset, mem_we is 0 and mem_addr is 0.
- R2: A data word is {first[5:0], second[5:0]}, with the first accepted member supplying bits 11..6.
- R3: If bit 6 of the first member is 1, the pair loads the target address and no write is issued.
- R4: A character with bit 7 set is accepted and discarded. It does not count as a pair member, whether it comes before a pair or between the two members, and it causes no write.
- R5: Every data word is written to the most recently loaded address. Consecutive data frames with no address frame between them all use that same address.
- R6: A data frame that comes before any address frame after reset is written to address 0.
- R7: The second member decides neither the frame kind nor its own use: bit 6 of the second member is ignored and only its low 6 bits are used.
- R8: mem_we is a one-cycle pulse in the cycle right after the second member of a data pair is accepted. mem_addr and mem_wdata are valid during that pulse.
- R9: char_ready equals enable. While enable is 0 no character is accepted, and a pair left half-received is dropped, so the next accepted character starts a new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Lets the loader accept characters |
| char_valid | input | 1 | A character is offered |
| char_data | input | 8 | Offered character |
| char_ready | output | 1 | The loader takes the offered character |
| mem_we | output | 1 | One-cycle write strobe |
| mem_addr | output | 12 | Write address, the most recently loaded address |
| mem_wdata | output | 12 | Write data |

## Verification
The write pulse for a finished data pair can fall in the same cycle as the acceptance of the next pair's first member. That cycle may also hold a discarded character.

The bench provokes this by holding char_valid high across a run of characters that mixes data pairs with a discarded character. It logs every strobe it sees.

The bench then checks three things:
- Each pulse lasts exactly one cycle.
- Each pulse carries the expected word and the held address.
- The number of writes matches the number of complete data pairs. This shows that overlapping acceptance neither loses nor splits a pair.

// File: rtl/rim_loader_pkg.sv
package rim_loader_pkg;

    // Role of one offered character given the current pairing phase
    typedef enum logic [1:0] {
        KIND_SKIP      = 2'd0,
        KIND_HEAD_ADDR = 2'd1,
        KIND_HEAD_DATA = 2'd2,
        KIND_TAIL      = 2'd3
    } char_kind_e;

endpackage

// File: rtl/rim_char_class.sv
module rim_char_class
    import rim_loader_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int HALF_W = 6
) (
    input  logic              take,
    input  logic              tail_expected,
    input  logic [CHAR_W-1:0] chr,
    output char_kind_e        kind,
    output logic [HALF_W-1:0] payload
);
    localparam int DROP_BIT = CHAR_W - 1;
    localparam int FLAG_BIT = HALF_W;

    assign payload = chr[HALF_W-1:0];

    always_comb begin
        if (!take || chr[DROP_BIT]) begin
            kind = KIND_SKIP;
        end else if (tail_expected) begin
            kind = KIND_TAIL;
        end else if (chr[FLAG_BIT]) begin
            kind = KIND_HEAD_ADDR;
        end else begin
            kind = KIND_HEAD_DATA;
        end
    end
endmodule

// File: rtl/rim_word_join.sv
module rim_word_join #(
    parameter int HALF_W = 6
) (
    input  logic [HALF_W-1:0]   upper,
    input  logic [HALF_W-1:0]   lower,
    output logic [2*HALF_W-1:0] word
);
    assign word = {upper, lower};
endmodule

// File: rtl/rim_tape_loader.sv
module rim_tape_loader
    import rim_loader_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int HALF_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  char_valid,
    input  logic [CHAR_W-1:0]     char_data,
    output logic                  char_ready,
    output logic                  mem_we,
    output logic [2*HALF_W-1:0]   mem_addr,
    output logic [2*HALF_W-1:0]   mem_wdata
);
    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        logic              tail;      // first member held, second awaited
        logic              addr_frm;  // held first member flagged an address
        logic [HALF_W-1:0] upper;
        logic [WORD_W-1:0] addr;
        logic              we;
        logic [WORD_W-1:0] wdata;
    } ld_state_t;

    ld_state_t st_d, st_q;

    char_kind_e        kind;
    logic [HALF_W-1:0] payload;
    logic [WORD_W-1:0] joined;
    logic              take;

    assign take       = enable && char_valid;
    assign char_ready = enable;

    rim_char_class #(.CHAR_W(CHAR_W), .HALF_W(HALF_W)) u_class (
        .take          (take),
        .tail_expected (st_q.tail),
        .chr           (char_data),
        .kind          (kind),
        .payload       (payload)
    );

    rim_word_join #(.HALF_W(HALF_W)) u_join (
        .upper (st_q.upper),
        .lower (payload),
        .word  (joined)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (!enable) begin
            st_d.tail = 1'b0;
        end else begin
            case (kind)
                KIND_HEAD_ADDR: begin
                    st_d.tail     = 1'b1;
                    st_d.addr_frm = 1'b1;
                    st_d.upper    = payload;
                end
                KIND_HEAD_DATA: begin
                    st_d.tail     = 1'b1;
                    st_d.addr_frm = 1'b0;
                    st_d.upper    = payload;
                end
                KIND_TAIL: begin
                    st_d.tail = 1'b0;
                    if (st_q.addr_frm) begin
                        st_d.addr = joined;
                    end else begin
                        st_d.we    = 1'b1;
                        st_d.wdata = joined;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.wdata;

    // R8
    we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R8
    we_after_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_TAIL && !st_q.addr_frm) |=> mem_we);

    // R3
    addr_frame_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_TAIL && st_q.addr_frm) |=> !mem_we);

    // R4
    drop_keeps_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && char_data[CHAR_W-1]) |=> (!mem_we && st_q.tail == $past(st_q.tail)));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(kind == KIND_TAIL && st_q.addr_frm) |=> $stable(mem_addr));

    // R9
    disabled_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!mem_we && !st_q.tail));
endmodule

// File: tb/rim_tape_loader_test.sv
`timescale 1ns/1ps
module rim_tape_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        char_valid = 1'b0;
    logic [7:0]  char_data = 8'h00;
    logic        char_ready;
    logic        mem_we;
    logic [11:0] mem_addr;
    logic [11:0] mem_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rim_tape_loader uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .char_valid(char_valid),
        .char_data(char_data), .char_ready(char_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // {first, second, expect_write, expect_addr, expect_data}
    localparam int NVEC = 6;
    localparam logic [40:0] VEC [NVEC] = '{
        {8'o012, 8'o034, 1'b1, 12'o0000, 12'o1234},  // R6 data before any address
        {8'o112, 8'o034, 1'b0, 12'o1234, 12'o0000},  // R3 address frame
        {8'o055, 8'o033, 1'b1, 12'o1234, 12'o5533},  // R2 assembly
        {8'o077, 8'o077, 1'b1, 12'o1234, 12'o7777},  // R5 address not advanced
        {8'o100, 8'o177, 1'b0, 12'o0077, 12'o0000},  // R7 second bit 6 ignored
        {8'o000, 8'o101, 1'b1, 12'o0077, 12'o0001}   // R7 on a data pair
    };

    // write log
    int          wcnt = 0;
    int          dbl  = 0;
    logic        prev_we = 1'b0;
    logic [11:0] log_a [16];
    logic [11:0] log_d [16];

    always @(negedge clk) begin
        if (mem_we) begin
            log_a[wcnt % 16] = mem_addr;
            log_d[wcnt % 16] = mem_wdata;
            wcnt = wcnt + 1;
            if (prev_we) dbl = dbl + 1;
        end
        prev_we = mem_we;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] c);
        @(negedge clk);
        char_valid = 1'b1;
        char_data  = c;
        @(negedge clk);
        char_valid = 1'b0;
    endtask

    logic [7:0] sbuf [8];
    task automatic stream(input int n);
        @(negedge clk);
        char_valid = 1'b1;
        for (int i = 0; i < n; i++) begin
            char_data = sbuf[i];
            @(negedge clk);
        end
        char_valid = 1'b0;
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 we", mem_we, 0);
        chk("R1 addr", mem_addr, 0);
        chk("R9 ready low", char_ready, 0);
        enable = 1'b1;
        @(negedge clk);
        chk("R9 ready high", char_ready, 1);

        for (int v = 0; v < NVEC; v++) begin
            send_char(VEC[v][40:33]);
            send_char(VEC[v][32:25]);
            chk("R8 strobe", mem_we, {31'd0, VEC[v][24]});
            chk("R5 addr", mem_addr, {20'd0, VEC[v][23:12]});
            if (VEC[v][24]) chk("R2 data", mem_wdata, {20'd0, VEC[v][11:0]});
            @(negedge clk);
            chk("R8 one cycle", mem_we, 0);
        end

        // R4: rubouts before and inside pairs
        send_char(8'o112); send_char(8'o377); send_char(8'o034);
        chk("R4 addr through rubout", mem_addr, 12'o1234);
        chk("R4 no write on addr", mem_we, 0);
        send_char(8'o377);
        chk("R4 rubout no write", mem_we, 0);
        send_char(8'o001); send_char(8'o002);
        chk("R4 write after lone rubout", mem_we, 1);
        chk("R4 data", mem_wdata, 12'o0102);
        send_char(8'o003); send_char(8'o377);
        chk("R4 rubout mid pair no write", mem_we, 0);
        send_char(8'o004);
        chk("R4 data split by rubout", mem_wdata, 12'o0304);
        chk("R4 strobe split by rubout", mem_we, 1);

        // R9: disable drops half pair and blocks acceptance
        send_char(8'o005);
        @(negedge clk);
        enable = 1'b0;
        char_valid = 1'b1;
        char_data = 8'o011;
        @(negedge clk);
        chk("R9 ready when disabled", char_ready, 0);
        @(negedge clk);
        chk("R9 no write when disabled", mem_we, 0);
        char_valid = 1'b0;
        enable = 1'b1;
        send_char(8'o006); send_char(8'o007);
        chk("R9 fresh pair strobe", mem_we, 1);
        chk("R9 fresh pair data", mem_wdata, 12'o0607);
        chk("R9 addr kept", mem_addr, 12'o1234);

        // R8 collision: strobe overlaps next acceptance, valid held high
        send_char(8'o120); send_char(8'o000);
        chk("R3 new address", mem_addr, 12'o2000);
        sbuf[0] = 8'o001; sbuf[1] = 8'o002; sbuf[2] = 8'o003; sbuf[3] = 8'o004;
        sbuf[4] = 8'o377; sbuf[5] = 8'o005; sbuf[6] = 8'o006;
        base = wcnt;
        dbl = 0;
        stream(7);
        @(negedge clk);
        chk("R8 stream write count", wcnt - base, 3);
        chk("R8 stream pulses single", dbl, 0);
        chk("R8 stream word 0", log_d[base % 16], 12'o0102);
        chk("R8 stream word 1", log_d[(base + 1) % 16], 12'o0304);
        chk("R4 stream word 2", log_d[(base + 2) % 16], 12'o0506);
        chk("R5 stream addr 0", log_a[base % 16], 12'o2000);
        chk("R5 stream addr 2", log_a[(base + 2) % 16], 12'o2000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule